// File: doc/BRIEF.md
# DMA Work-Unit Transition Controller

This block runs one DMA channel through a series of work units. A descriptor arrives on a ready/valid port and gives a base address, an inner count, an outer count, an inner stride, a row stride and a synchronize flag. The block copies these values into its working registers and then takes one data item per handshake on the upstream side. Each item is tagged with the address generated for it and goes into a small FIFO. The FIFO hands items to the destination on a ready/valid handshake.

The synchronize flag decides what happens between two work units, and how it is read depends on the channel direction. A transmit channel reads the flag of the unit that is finishing. When that flag is set, the channel empties its FIFO before it asks for the next descriptor. A receive channel reads the flag of the unit that is starting. When that flag is set, anything still in the FIFO is thrown away in the cycle the new descriptor is accepted. With the flag clear, in either direction, the FIFO keeps delivering while the channel waits for or loads its next descriptor.

A one-cycle completion pulse marks the end of each work unit. A fetch status output shows when the channel is waiting for or loading a descriptor.

Top module: `dma_wu_ctrl`

## Requirements
- R1: When a descriptor is accepted, the working address is loaded from `desc_base`, the inner count from `desc_inner` and the outer count from `desc_outer`. The first item of the unit carries `desc_base` as its address.
- R2: `st_fetch` is 1 while the channel waits for a descriptor and during the cycle after acceptance, when the working registers load. `up_ready` is 0 whenever `st_fetch` is 1. In the second cycle after the accepting edge, `st_fetch` is 0 and items are accepted if the FIFO has room.
- R3: After each item the address moves by `desc_in_step`. After the last item of a row, it moves by `desc_row_step` instead, the inner count reloads and the outer count drops by one. A count of 0 behaves as 1, and a unit carries max(inner,1)*max(outer,1) items.
- R4: The FIFO holds `FIFO_DEPTH` items. `up_ready` is 0 while the FIFO is full. Items leave in arrival order as {`dn_addr`,`dn_data`}, one per cycle with `dn_valid` and `dn_ready` both 1.
- R5: On a transmit channel (`cfg_rx`=0), a finishing unit with sync 0 raises `desc_ready` in the cycle after its last item is accepted. The FIFO keeps delivering while the channel waits for a descriptor.
- R6: On a transmit channel, a finishing unit with sync 1 keeps `desc_ready` at 0 until the FIFO is empty. `desc_ready` rises one cycle after the FIFO empties.
- R7: On a receive channel (`cfg_rx`=1), the flag of the finishing unit is ignored. Accepting a descriptor with sync 1 empties the FIFO at that clock edge, so `dn_valid` is 0 in the following cycle. With sync 0, the held items stay and are still delivered.
- R8: `done_irq` is a one-cycle pulse per unit. On a transmit channel with sync 1 it comes in the first cycle of `desc_ready`=1 after the drain. Otherwise it comes in the cycle after the last item of the unit is accepted.
- R9: After reset, `desc_ready`=1, `st_fetch`=1, `up_ready`=0, `dn_valid`=0 and `done_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx | input | 1 | Channel direction: 1 receive, 0 transmit |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Channel takes a descriptor |
| desc_base | input | 16 | Start address of the unit |
| desc_inner | input | 8 | Items per row |
| desc_outer | input | 8 | Rows per unit |
| desc_in_step | input | 16 | Address step within a row |
| desc_row_step | input | 16 | Address step after a row's last item |
| desc_sync | input | 1 | Synchronize flag of the unit |
| up_valid | input | 1 | Upstream item offered |
| up_ready | output | 1 | Upstream item taken |
| up_data | input | 16 | Upstream item data |
| dn_valid | output | 1 | Item available to destination |
| dn_ready | input | 1 | Destination takes the item |
| dn_addr | output | 16 | Address tag of the item |
| dn_data | output | 16 | Data of the item |
| st_fetch | output | 1 | Waiting for or loading a descriptor |
| done_irq | output | 1 | Work-unit completion pulse |

## Verification
The unit boundary is exercised four ways, with the destination stalled so the FIFO still holds data when a unit ends:
- A transmit unit with sync clear is followed by a long pause. This shows whether data keeps moving while the channel waits.
- A transmit unit with sync set shows whether descriptor acceptance and the completion pulse wait for the drain.
- On a receive channel, a unit with sync set is followed by one with sync clear, which shows that only the incoming flag counts.
- A receive descriptor with sync set, arriving over buffered data, shows that the flush happens.

Address patterns cover plain rows, multi-row units and zero counts, which separate row-step handling from inner-step handling. A longer unit against a stalled destination shows the FIFO's full point. A toggling destination ready checks that order is kept under irregular drain.

// File: rtl/dwu_pkg.sv
`timescale 1ns/1ps
package dwu_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned DATA_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_e;

    typedef struct packed {
        addr_t base;
        cnt_t  inner;
        cnt_t  outer;
        addr_t in_step;
        addr_t row_step;
        logic  sync;
    } wu_desc_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } xfer_item_t;

    // transmit side: the finishing unit's flag asks for an empty FIFO first
    function automatic logic drain_before_next(input logic is_rx, input logic outgoing_sync);
        return !is_rx && outgoing_sync;
    endfunction

    // receive side: the starting unit's flag discards buffered items
    function automatic logic flush_on_accept(input logic is_rx, input logic incoming_sync);
        return is_rx && incoming_sync;
    endfunction

    // zero and one are both "last position"
    function automatic logic more_than_one(input cnt_t c);
        return c > cnt_t'(1);
    endfunction
endpackage

// File: rtl/dwu_fifo.sv
`timescale 1ns/1ps
module dwu_fifo
    import dwu_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         flush,
    input  xfer_item_t                   wr_item,
    output xfer_item_t                   rd_item,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);

    xfer_item_t       slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_item = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            slots[wr_ptr] <= wr_item;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/dwu_agen.sv
`timescale 1ns/1ps
module dwu_agen
    import dwu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  step,
    input  addr_t base,
    input  cnt_t  inner,
    input  cnt_t  outer,
    input  addr_t in_step,
    input  addr_t row_step,
    output addr_t addr,
    output logic  last
);
    cnt_t inner_left;
    cnt_t outer_left;

    assign last = !more_than_one(inner_left) && !more_than_one(outer_left);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr       <= '0;
            inner_left <= '0;
            outer_left <= '0;
        end else if (load) begin
            addr       <= base;
            inner_left <= inner;
            outer_left <= outer;
        end else if (step) begin
            if (more_than_one(inner_left)) begin
                inner_left <= inner_left - 1'b1;
                addr       <= addr + in_step;
            end else if (more_than_one(outer_left)) begin
                outer_left <= outer_left - 1'b1;
                inner_left <= inner;
                addr       <= addr + row_step;
            end
        end
    end
endmodule

// File: rtl/dwu_seq.sv
`timescale 1ns/1ps
module dwu_seq
    import dwu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       is_rx,
    input  logic       desc_valid,
    input  wu_desc_t   desc_in,
    output logic       desc_ready,
    output wu_desc_t   held,
    output seq_state_e state,
    output logic       load_wu,
    output logic       flush,
    input  logic       fifo_empty,
    input  logic       item_fire,
    input  logic       item_last,
    output logic       done_irq
);
    logic accept;

    assign desc_ready = (state == ST_FETCH);
    assign accept     = desc_valid && desc_ready;
    assign flush      = accept && flush_on_accept(is_rx, desc_in.sync);
    assign load_wu    = (state == ST_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FETCH;
            held     <= '0;
            done_irq <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            case (state)
                ST_FETCH: begin
                    if (accept) begin
                        held  <= desc_in;
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    state <= ST_RUN;
                end
                ST_RUN: begin
                    if (item_fire && item_last) begin
                        if (drain_before_next(is_rx, held.sync)) begin
                            state <= ST_DRAIN;
                        end else begin
                            state    <= ST_FETCH;
                            done_irq <= 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (fifo_empty) begin
                        state    <= ST_FETCH;
                        done_irq <= 1'b1;
                    end
                end
                default: state <= ST_FETCH;
            endcase
        end
    end
endmodule

// File: rtl/dma_wu_ctrl.sv
`timescale 1ns/1ps
module dma_wu_ctrl
    import dwu_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rx,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [CNT_W-1:0]  desc_inner,
    input  logic [CNT_W-1:0]  desc_outer,
    input  logic [ADDR_W-1:0] desc_in_step,
    input  logic [ADDR_W-1:0] desc_row_step,
    input  logic              desc_sync,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_data,
    output logic              st_fetch,
    output logic              done_irq
);
    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);

    wu_desc_t         desc_in;
    wu_desc_t         held;
    seq_state_e       seq_state;
    logic             load_wu;
    logic             flush;
    logic             fifo_empty;
    logic             fifo_full;
    logic [LVL_W-1:0] fifo_level;
    logic             item_fire;
    logic             item_last;
    addr_t            cur_addr;
    xfer_item_t       wr_item;
    xfer_item_t       rd_item;

    assign desc_in = '{base: desc_base, inner: desc_inner, outer: desc_outer,
                       in_step: desc_in_step, row_step: desc_row_step, sync: desc_sync};

    assign up_ready  = (seq_state == ST_RUN) && !fifo_full;
    assign item_fire = up_valid && up_ready;
    assign st_fetch  = (seq_state == ST_FETCH) || (seq_state == ST_LOAD);
    assign wr_item   = '{addr: cur_addr, data: up_data};
    assign dn_valid  = !fifo_empty;
    assign dn_addr   = rd_item.addr;
    assign dn_data   = rd_item.data;

    dwu_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .is_rx      (cfg_rx),
        .desc_valid (desc_valid),
        .desc_in    (desc_in),
        .desc_ready (desc_ready),
        .held       (held),
        .state      (seq_state),
        .load_wu    (load_wu),
        .flush      (flush),
        .fifo_empty (fifo_empty),
        .item_fire  (item_fire),
        .item_last  (item_last),
        .done_irq   (done_irq)
    );

    dwu_agen u_agen (
        .clk      (clk),
        .rst      (rst),
        .load     (load_wu),
        .step     (item_fire),
        .base     (held.base),
        .inner    (held.inner),
        .outer    (held.outer),
        .in_step  (held.in_step),
        .row_step (held.row_step),
        .addr     (cur_addr),
        .last     (item_last)
    );

    dwu_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (item_fire),
        .pop     (dn_valid && dn_ready),
        .flush   (flush),
        .wr_item (wr_item),
        .rd_item (rd_item),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .level   (fifo_level)
    );
endmodule

// File: rtl/dwu_chk.sv
`timescale 1ns/1ps
module dwu_chk
    import dwu_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            cfg_rx,
    input logic                            desc_valid,
    input logic                            desc_ready,
    input logic                            desc_sync,
    input logic                            up_valid,
    input logic                            up_ready,
    input logic                            dn_valid,
    input logic                            st_fetch,
    input logic                            done_irq,
    input seq_state_e                      seq_state,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level
);
    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);

    // R2
    fetch_blocks_issue_chk: assert property (@(posedge clk) disable iff (rst)
        st_fetch |-> !up_ready);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready) |-> (fifo_level < LVL_W'(FIFO_DEPTH)));

    // R7
    rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_ready && cfg_rx && desc_sync) |=> !dn_valid);

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq);

    // R6
    drain_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (done_irq && !cfg_rx && ($past(seq_state) == ST_DRAIN)) |-> !dn_valid);
endmodule

bind dma_wu_ctrl dwu_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_rx     (cfg_rx),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_sync  (desc_sync),
    .up_valid   (up_valid),
    .up_ready   (up_ready),
    .dn_valid   (dn_valid),
    .st_fetch   (st_fetch),
    .done_irq   (done_irq),
    .seq_state  (seq_state),
    .fifo_level (fifo_level)
);

// File: tb/dma_wu_ctrl_bench.sv
`timescale 1ns/1ps
module dma_wu_ctrl_bench;
    import dwu_pkg::*;

    localparam int DEPTH = 4;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  cfg_rx = 1'b0;
    logic  desc_valid = 1'b0;
    logic  desc_ready;
    addr_t desc_base = '0;
    cnt_t  desc_inner = '0;
    cnt_t  desc_outer = '0;
    addr_t desc_in_step = '0;
    addr_t desc_row_step = '0;
    logic  desc_sync = 1'b0;
    logic  up_valid = 1'b0;
    logic  up_ready;
    data_t up_data = '0;
    logic  dn_valid;
    logic  dn_ready = 1'b0;
    addr_t dn_addr;
    data_t dn_data;
    logic  st_fetch;
    logic  done_irq;

    always #4 clk = ~clk;

    dma_wu_ctrl #(.FIFO_DEPTH(DEPTH)) u_dma_wu_ctrl (
        .clk(clk), .rst(rst), .cfg_rx(cfg_rx),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_base(desc_base), .desc_inner(desc_inner), .desc_outer(desc_outer),
        .desc_in_step(desc_in_step), .desc_row_step(desc_row_step), .desc_sync(desc_sync),
        .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data),
        .st_fetch(st_fetch), .done_irq(done_irq)
    );

    int         checks = 0;
    int         fails = 0;
    int         accepted = 0;
    bit         dn_hold = 1'b1;
    bit         dn_toggle = 1'b0;
    xfer_item_t exp_q[$];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // destination ready pattern, changed just after each edge
    always begin
        @(posedge clk);
        #1;
        dn_ready = dn_hold ? 1'b0 : (dn_toggle ? ~dn_ready : 1'b1);
    end

    // scoreboard monitor: compares deliveries, models the receive flush (R7)
    always @(negedge clk) begin
        xfer_item_t e;
        if (!rst) begin
            if (dn_valid && dn_ready) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R4 unexpected item: actual %0h expected none", {dn_addr, dn_data});
                end else begin
                    e = exp_q.pop_front();
                    chk("R3", "delivered item {addr,data}", {dn_addr, dn_data}, e);
                end
            end
            if (desc_valid && desc_ready && cfg_rx && desc_sync) begin
                exp_q.delete();
            end
        end
    end

    task automatic do_reset(input logic rx);
        rst = 1'b1;
        cfg_rx = rx;
        dn_hold = 1'b1;
        dn_toggle = 1'b0;
        repeat (3) step();
        exp_q.delete();
        rst = 1'b0;
    endtask

    task automatic give_desc(input wu_desc_t d);
        bit got;
        desc_base = d.base;
        desc_inner = d.inner;
        desc_outer = d.outer;
        desc_in_step = d.in_step;
        desc_row_step = d.row_step;
        desc_sync = d.sync;
        desc_valid = 1'b1;
        do begin
            @(negedge clk);
            got = desc_ready;
            step();
        end while (!got);
        desc_valid = 1'b0;
    endtask

    task automatic feed(input wu_desc_t d, input int data0);
        int    ni;
        int    no;
        addr_t a;
        bit    got;
        xfer_item_t it;
        ni = (d.inner == 0) ? 1 : int'(d.inner);
        no = (d.outer == 0) ? 1 : int'(d.outer);
        a = d.base;
        for (int o = 0; o < no; o++) begin
            for (int i = 0; i < ni; i++) begin
                up_valid = 1'b1;
                up_data = data_t'(data0 + o * ni + i);
                do begin
                    @(negedge clk);
                    got = up_ready;
                    if (got) begin
                        it.addr = a;
                        it.data = up_data;
                        exp_q.push_back(it);
                        accepted++;
                    end
                    step();
                end while (!got);
                if (i < ni - 1) a = a + d.in_step;
                else if (o < no - 1) a = a + d.row_step;
            end
        end
        up_valid = 1'b0;
    endtask

    task automatic wait_desc_ready();
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (desc_ready) break;
            step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wu_desc_t d;

        // ---------- reset state (R9)
        do_reset(1'b0);
        @(negedge clk);
        chk("R9", "desc_ready", desc_ready, 1);
        chk("R9", "st_fetch", st_fetch, 1);
        chk("R9", "up_ready", up_ready, 0);
        chk("R9", "dn_valid", dn_valid, 0);
        chk("R9", "done_irq", done_irq, 0);
        step();

        // ---------- transmit, continuous transition (R1 R2 R5 R8)
        d = '{base: 16'h0100, inner: 8'd3, outer: 8'd1, in_step: 16'd4, row_step: 16'h10, sync: 1'b0};
        give_desc(d);
        @(negedge clk);
        chk("R2", "st_fetch during load", st_fetch, 1);
        chk("R2", "up_ready during load", up_ready, 0);
        step();
        @(negedge clk);
        chk("R2", "st_fetch after load", st_fetch, 0);
        chk("R2", "up_ready after load", up_ready, 1);
        step();
        feed(d, 'h10);
        @(negedge clk);
        chk("R5", "desc_ready after last item", desc_ready, 1);
        chk("R8", "done_irq after last item", done_irq, 1);
        chk("R1", "first address tag", dn_addr, 16'h0100);
        chk("R1", "item held", dn_valid, 1);
        step();
        @(negedge clk);
        chk("R8", "done_irq pulse ends", done_irq, 0);
        dn_hold = 1'b0;
        repeat (8) step();
        @(negedge clk);
        chk("R5", "items left during pause", exp_q.size(), 0);
        chk("R5", "still waiting for descriptor", desc_ready, 1);
        step();

        // ---------- transmit, sync, longer than FIFO (R4 R6 R8)
        d = '{base: 16'h0200, inner: 8'd3, outer: 8'd2, in_step: 16'd1, row_step: 16'h20, sync: 1'b1};
        dn_hold = 1'b1;
        give_desc(d);
        accepted = 0;
        fork
            feed(d, 'h20);
        join_none
        repeat (10) step();
        @(negedge clk);
        chk("R4", "items taken while stalled", accepted, DEPTH);
        chk("R4", "up_ready when full", up_ready, 0);
        dn_hold = 1'b0;
        dn_toggle = 1'b1;
        wait fork;
        wait_desc_ready();
        chk("R6", "fifo drained before descriptor", exp_q.size(), 0);
        chk("R8", "done_irq with desc_ready after drain", done_irq, 1);
        step();

        // ---------- transmit, sync with stalled destination (R6 R8)
        d = '{base: 16'h0300, inner: 8'd2, outer: 8'd2, in_step: 16'd1, row_step: 16'h20, sync: 1'b1};
        dn_hold = 1'b1;
        dn_toggle = 1'b0;
        give_desc(d);
        feed(d, 'h30);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R6", "desc_ready held during drain", desc_ready, 0);
            chk("R8", "no done_irq before drain", done_irq, 0);
            step();
        end
        dn_hold = 1'b0;
        wait_desc_ready();
        chk("R6", "fifo empty at descriptor request", exp_q.size(), 0);
        chk("R8", "done_irq after drain", done_irq, 1);
        step();

        // ---------- zero counts (R3)
        dn_toggle = 1'b1;
        d = '{base: 16'h0400, inner: 8'd0, outer: 8'd3, in_step: 16'd5, row_step: 16'h40, sync: 1'b0};
        give_desc(d);
        accepted = 0;
        feed(d, 'h40);
        chk("R3", "items with inner count 0", accepted, 3);
        d = '{base: 16'h0500, inner: 8'd0, outer: 8'd0, in_step: 16'd5, row_step: 16'h40, sync: 1'b0};
        give_desc(d);
        accepted = 0;
        feed(d, 'h48);
        @(negedge clk);
        chk("R3", "items with both counts 0", accepted, 1);
        chk("R8", "done_irq after single item", done_irq, 1);
        repeat (12) step();
        chk("R3", "zero-count items delivered", exp_q.size(), 0);

        // ---------- receive, incoming flag clear keeps data (R7 R8)
        do_reset(1'b1);
        d = '{base: 16'h0600, inner: 8'd2, outer: 8'd1, in_step: 16'd2, row_step: 16'h0, sync: 1'b1};
        give_desc(d);
        feed(d, 'h60);
        @(negedge clk);
        chk("R8", "rx done_irq after last item", done_irq, 1);
        chk("R7", "rx desc_ready after last item", desc_ready, 1);
        step();
        d = '{base: 16'h0700, inner: 8'd2, outer: 8'd1, in_step: 16'd2, row_step: 16'h0, sync: 1'b0};
        give_desc(d);
        @(negedge clk);
        chk("R7", "rx data kept on sync 0", dn_valid, 1);
        chk("R7", "rx oldest item kept", dn_addr, 16'h0600);
        step();
        dn_hold = 1'b0;
        feed(d, 'h70);
        repeat (10) step();
        chk("R7", "rx kept items delivered", exp_q.size(), 0);

        // ---------- receive, incoming flag set flushes (R7)
        dn_hold = 1'b1;
        d = '{base: 16'h0800, inner: 8'd3, outer: 8'd1, in_step: 16'd1, row_step: 16'h0, sync: 1'b0};
        give_desc(d);
        feed(d, 'h80);
        d = '{base: 16'h0900, inner: 8'd1, outer: 8'd2, in_step: 16'd0, row_step: 16'h8, sync: 1'b1};
        give_desc(d);
        @(negedge clk);
        chk("R7", "rx flush on sync 1", dn_valid, 0);
        step();
        dn_hold = 1'b0;
        feed(d, 'h90);
        repeat (10) step();
        chk("R7", "rx items after flush delivered", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule